// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks the frame to evict from a fixed pool of page frames. Each frame carries a valid flag, driven in from outside as a vector, and an accessed flag held inside the block. Whenever the frame is used, the surrounding logic reports it on the reference port, and the accessed flag of that frame is set.

When eviction is needed, a single request strobe starts a search. A hand pointer walks the frames in circular order and tests one frame per clock. A frame whose accessed flag is set gets a second chance: the flag is cleared and the hand moves on. The first frame found empty or not recently used is returned with a one-cycle done pulse. The hand then rests one frame past that victim, so the next search starts there. With no references arriving during the walk, a search ends within N+1 tested frames.

Top module: `clock_victim_sel`

## Requirements
- R1: During a search the hand tests exactly one frame per clock and advances by one, wrapping from frame N-1 to frame 0.
- R2: A valid frame under the hand whose accessed flag is clear is chosen as the victim.
- R3: A valid frame under the hand whose accessed flag is set has that flag cleared, and the hand moves on. With every frame valid and referenced, the search returns the start frame after N+1 tested frames.
- R4: A reference (ref_valid_i high with frame index ref_idx_i) sets that frame's accessed flag, whether a search is running or not.
- R5: A frame whose frame_valid_i bit is low is chosen as the victim as soon as the hand reaches it, whatever its accessed flag holds.
- R6: After a victim is reported the hand rests on the next frame in circular order, and the next search tests that frame first.
- R7: When a reference and a hand clear target the same frame in the same cycle, the reference wins and the flag stays set.
- R8: A request strobe that arrives while a search is running is ignored. It neither restarts the search nor produces a second done pulse.
- R9: After reset the hand is on frame 0, all accessed flags are clear, done_o is low and victim_o is 0.
- R10: done_o is a one-cycle pulse raised k+1 clocks after the clock that samples the request, where k is the number of frames skipped. victim_o holds its value until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Search request strobe, taken only while idle |
| ref_valid_i | input | 1 | Reference strobe |
| ref_idx_i | input | IDX_W | Frame index being referenced |
| frame_valid_i | input | NUM_FRAMES | Valid flag of each frame, bit i for frame i |
| done_o | output | 1 | One-cycle pulse: a victim was found |
| victim_o | output | IDX_W | Index of the last victim chosen |

## Verification
The bench aims at the frames that need a full turn of the hand. In the all-referenced case, a design that stops one frame early or late returns the wrong frame and the wrong latency. It sets up a reference that lands on the frame being cleared in the same cycle. A design that lets the clear win evicts that frame instead of the one after it. It also parks the hand mid-ring and checks that the next search starts one past the last victim rather than at frame 0. Other cases are invalid frames with their accessed flag set, which must be taken at once rather than skipped, and stray request strobes during a walk, which must not cause a second pulse.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_t;
endpackage

// File: rtl/clock_hand_ptr.sv
module clock_hand_ptr #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  output logic [IDX_W-1:0] hand_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  logic [IDX_W-1:0] hand_q;
  logic [IDX_W-1:0] hand_next;

  // Wrap explicitly so a ring size that is not a power of two also works.
  always_comb begin
    if (hand_q == LAST) hand_next = '0;
    else                hand_next = hand_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         hand_q <= '0;
    else if (step_i) hand_q <= hand_next;
  end

  assign hand_o = hand_q;
endmodule

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_en_i,
  input  logic [IDX_W-1:0]      set_idx_i,
  input  logic                  clr_en_i,
  input  logic [IDX_W-1:0]      clr_idx_i,
  output logic [NUM_FRAMES-1:0] bits_o
);
  logic [NUM_FRAMES-1:0] bits_q;

  // One flop per frame. The set path is tested first, so a reference
  // outranks a clear aimed at the same frame in the same cycle.
  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_bit
    logic hit_set;
    logic hit_clr;
    assign hit_set = set_en_i && (set_idx_i == IDX_W'(i));
    assign hit_clr = clr_en_i && (clr_idx_i == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)          bits_q[i] <= 1'b0;
      else if (hit_set) bits_q[i] <= 1'b1;
      else if (hit_clr) bits_q[i] <= 1'b0;
    end
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import cvs_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [IDX_W-1:0] hand_i,
  input  logic             acc_here_i,
  input  logic             valid_here_i,
  output logic             step_o,
  output logic             clr_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] victim_o
);
  sweep_state_t     state_q;
  logic             found;
  logic             done_q;
  logic [IDX_W-1:0] victim_q;

  assign busy_o   = (state_q == SWEEP_RUN);
  assign found    = busy_o && (!valid_here_i || !acc_here_i);
  assign clr_en_o = busy_o && valid_here_i && acc_here_i;
  assign step_o   = busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SWEEP_IDLE;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SWEEP_IDLE: if (req_i) state_q <= SWEEP_RUN;
        SWEEP_RUN: begin
          if (found) begin
            state_q  <= SWEEP_IDLE;
            done_q   <= 1'b1;
            victim_q <= hand_i;
          end
        end
        default: state_q <= SWEEP_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign victim_o = victim_q;
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_i,
  input  logic                  ref_valid_i,
  input  logic [IDX_W-1:0]      ref_idx_i,
  input  logic [NUM_FRAMES-1:0] frame_valid_i,
  output logic                  done_o,
  output logic [IDX_W-1:0]      victim_o
);
  logic [IDX_W-1:0]      hand_w;
  logic [NUM_FRAMES-1:0] acc_w;
  logic                  step_w;
  logic                  clr_en_w;
  logic                  busy_w;

  clock_hand_ptr #(.NUM_FRAMES(NUM_FRAMES)) u_hand (
    .clk    (clk),
    .rst    (rst),
    .step_i (step_w),
    .hand_o (hand_w)
  );

  ref_bit_array #(.NUM_FRAMES(NUM_FRAMES)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .set_en_i  (ref_valid_i),
    .set_idx_i (ref_idx_i),
    .clr_en_i  (clr_en_w),
    .clr_idx_i (hand_w),
    .bits_o    (acc_w)
  );

  sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .hand_i       (hand_w),
    .acc_here_i   (acc_w[hand_w]),
    .valid_here_i (frame_valid_i[hand_w]),
    .step_o       (step_w),
    .clr_en_o     (clr_en_w),
    .busy_o       (busy_w),
    .done_o       (done_o),
    .victim_o     (victim_o)
  );
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_i,
  input logic                  ref_valid_i,
  input logic [IDX_W-1:0]      ref_idx_i,
  input logic [NUM_FRAMES-1:0] frame_valid_i,
  input logic                  done_o,
  input logic [IDX_W-1:0]      victim_o,
  input logic [IDX_W-1:0]      hand_q,
  input logic [NUM_FRAMES-1:0] acc_q,
  input logic                  busy_q
);
  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] h);
    return (h == IDX_W'(NUM_FRAMES - 1)) ? '0 : h + 1'b1;
  endfunction

  logic             valid_here;
  logic             acc_here;
  logic             ref_here;
  logic             seen_clk;

  assign valid_here = frame_valid_i[hand_q];
  assign acc_here   = acc_q[hand_q];
  assign ref_here   = ref_valid_i && (ref_idx_i == hand_q);

  always_ff @(posedge clk) begin
    if (rst) seen_clk <= 1'b0;
    else     seen_clk <= 1'b1;
  end

  AST_HAND_STEPS_ONE: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> hand_q == nxt($past(hand_q)));  // R1

  AST_HAND_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> $stable(hand_q));  // R1

  AST_CLEAR_BIT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (busy_q && valid_here && !acc_here) |=> done_o && victim_o == $past(hand_q));  // R2

  AST_SET_BIT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && valid_here && acc_here && !ref_here) |=> !done_o && !acc_q[$past(hand_q)]);  // R3

  AST_REF_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
    ref_valid_i |=> acc_q[$past(ref_idx_i)]);  // R4

  AST_INVALID_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !valid_here) |=> done_o && victim_o == $past(hand_q));  // R5

  AST_HAND_PAST_VICTIM: assert property (@(posedge clk) disable iff (rst)
    done_o |-> hand_q == nxt(victim_o));  // R6

  AST_REF_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (busy_q && valid_here && acc_here && ref_here) |=> acc_q[$past(hand_q)]);  // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);  // R10

  AST_VICTIM_HELD: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && !done_o) |-> $stable(victim_o));  // R10

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_q);  // R8
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_i         (req_i),
  .ref_valid_i   (ref_valid_i),
  .ref_idx_i     (ref_idx_i),
  .frame_valid_i (frame_valid_i),
  .done_o        (done_o),
  .victim_o      (victim_o),
  .hand_q        (hand_w),
  .acc_q         (acc_w),
  .busy_q        (busy_w)
);

// File: tb/clock_victim_sel_test.sv
module clock_victim_sel_test;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_i = 1'b0;
  logic          ref_valid_i = 1'b0;
  logic [IW-1:0] ref_idx_i = '0;
  logic [N-1:0]  frame_valid_i = '1;
  logic          done_o;
  logic [IW-1:0] victim_o;

  int checks = 0;
  int errors = 0;

  // Bench model of the ring state.
  logic [N-1:0]  m_acc;
  logic [IW-1:0] m_hand;

  always #2.5 clk = ~clk;

  clock_victim_sel #(.NUM_FRAMES(N)) uut (
    .clk(clk), .rst(rst), .req_i(req_i), .ref_valid_i(ref_valid_i),
    .ref_idx_i(ref_idx_i), .frame_valid_i(frame_valid_i),
    .done_o(done_o), .victim_o(victim_o)
  );

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] wrap(input logic [IW-1:0] h);
    return (h == IW'(N - 1)) ? '0 : h + 1'b1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_i = 1'b0; ref_valid_i = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_acc = '0; m_hand = '0;
  endtask

  task automatic touch(input int idx);
    @(negedge clk);
    ref_valid_i = 1'b1; ref_idx_i = IW'(idx);
    @(negedge clk);
    ref_valid_i = 1'b0;
    m_acc[idx] = 1'b1;
  endtask

  // Model search: returns victim and expected latency (skipped + 1).
  task automatic model_search(output int vic, output int lat);
    int skip = 0;
    logic [IW-1:0] h = m_hand;
    while (frame_valid_i[h] && m_acc[h]) begin
      m_acc[h] = 1'b0; h = wrap(h); skip++;
    end
    vic = h; lat = skip + 1; m_hand = wrap(h);
  endtask

  // Starts a search, counts clocks to done; returns -1 latency on timeout.
  task automatic run_search(output int vic, output int lat);
    @(negedge clk);
    req_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    lat = -1; vic = -1;
    for (int c = 1; c <= 4 * N; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (done_o) begin lat = c; vic = victim_o; break; end
    end
  endtask

  task automatic search_and_check(input string tag);
    int ev, el, av, al;
    model_search(ev, el);
    run_search(av, al);
    check({tag, " victim"}, av, ev);
    check({tag, " latency"}, al, el);
  endtask

  initial begin
    int av, al;
    m_acc = '0; m_hand = '0;
    process::self().srandom(32'h5EC0_0D01);
    do_reset();

    // R9: reset state
    check("R9 done low", int'(done_o), 0);
    check("R9 victim zero", int'(victim_o), 0);
    search_and_check("R9 first search");           // victim 0, latency 1

    // R6: next search starts one past victim
    search_and_check("R6 resume past victim");     // victim 1

    // R3/R1: all referenced -> full turn back to start frame
    do_reset();
    for (int i = 0; i < N; i++) touch(i);
    search_and_check("R3 full sweep");             // victim 0, latency N+1
    search_and_check("R1 after wrap");             // victim 1

    // R2: clear frame mid-ring taken
    do_reset();
    for (int i = 0; i < N; i++) if (i != 5) touch(i);
    search_and_check("R2 first clear frame");      // victim 5, latency 6

    // R5: invalid frame with accessed set taken at once
    do_reset();
    for (int i = 0; i < N; i++) touch(i);
    frame_valid_i = '1; frame_valid_i[3] = 1'b0;
    search_and_check("R5 invalid frame");          // victim 3, latency 4
    frame_valid_i = '1;

    // R7: reference on frame 0 in the same cycle the hand clears it
    do_reset();
    for (int i = 0; i < N; i++) touch(i);
    @(negedge clk);
    req_i = 1'b1;
    @(posedge clk);                // request sampled
    @(negedge clk);
    req_i = 1'b0;
    ref_valid_i = 1'b1; ref_idx_i = '0;  // sampled on the clock that tests frame 0
    @(posedge clk);
    @(negedge clk);
    ref_valid_i = 1'b0;
    al = -1; av = -1;
    for (int c = 2; c <= 4 * N; c++) begin
      @(posedge clk); @(negedge clk);
      if (done_o) begin al = c; av = victim_o; break; end
    end
    check("R7 reference wins victim", av, 1);
    check("R7 reference wins latency", al, N + 2);

    // R8: extra request strobe during a walk is ignored
    do_reset();
    for (int i = 0; i < N; i++) touch(i);
    @(negedge clk);
    req_i = 1'b1;
    @(posedge clk); @(negedge clk);
    req_i = 1'b0;
    @(posedge clk); @(negedge clk);
    req_i = 1'b1;                  // stray strobe mid-walk
    @(posedge clk); @(negedge clk);
    req_i = 1'b0;
    al = 0; av = 0;
    for (int c = 3; c <= 3 * N; c++) begin
      @(posedge clk); @(negedge clk);
      if (done_o) begin al++; if (al == 1) av = c; end
    end
    check("R8 single done pulse", al, 1);
    check("R8 latency unchanged", av, N + 1);
    check("R10 victim held", int'(victim_o), 0);

    // R4/R10: random references and valid patterns against the model
    do_reset();
    for (int t = 0; t < 300; t++) begin
      int nref = $urandom_range(0, N);
      for (int k = 0; k < nref; k++) touch($urandom_range(0, N - 1));
      if ($urandom_range(0, 3) == 0) frame_valid_i = N'($urandom);
      else frame_valid_i = '1;
      search_and_check("R4 R10 random");
    end
    frame_valid_i = '1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule